// File: doc/BRIEF.md
# Power-Good Strap Latch Controller

This block brings a clock generator from power-on to normal running and captures its two frequency-select straps exactly once. After power-on reset it waits for the active-low power-good strobe. It passes that strobe through a two-flop synchroniser. Once the strobe has been seen low, the block lets a settling delay run out and then captures both strap pins. It then lets a second delay run out before it enables the clock outputs. From that point the strobe and both strap pins have no further effect until the next power-on reset.

Each strap pin arrives as a two-bit level code produced by an analog detector outside this block. If the second strap (B) reads mid level at capture, the block locks into a test mode. In test mode the outputs stay disabled, and the first strap (A) chooses, with no clock involved, between a high-impedance output state and a reference-divided output state. Only a power-on reset leaves test mode. In normal operation the latched two-bit code selects one of four CPU frequencies. A live double-rate input selects a doubled frequency table.

Both delays are counted in reference-clock cycles and are set by parameters. The defaults correspond to roughly 0.25 ms and 1 ms at 14.318 MHz.

Top module: `pgood_strap_ctrl`

## Requirements
- R1: While `rst_n_i` is low at a clock edge, every output register clears: `straps_valid_o`, `test_mode_o`, `out_en_o`, `hiz_sel_o`, `cpu_code_o`, `strap_fs_o` and `cpu_mhz_o` all read 0 after that edge.
- R2: While the synchronised power-good strobe stays high, no strap capture takes place and `straps_valid_o` stays 0.
- R3: `pwrgd_n_i` may fall just before clock edge E1. The straps are captured at edge E(SETTLE_CYC+3), which allows two synchroniser stages, one cycle to start the delay and SETTLE_CYC delay cycles. `straps_valid_o` first reads 1 after that edge.
- R4: In normal operation `out_en_o` first reads 1 after edge E(SETTLE_CYC+RAMP_CYC+3). It then stays 1, and it never reads 1 while `straps_valid_o` is 0.
- R5: Level code on a strap pin: 2'b00 means low, 2'b01 means mid, and 2'b10 or 2'b11 means high. Any level other than high counts as bit 0. After capture, `cpu_code_o` = {A is high, B is high} and `strap_fs_o` = {B is high, A is high}.
- R6: With `dbl_rate_i` = 0 in normal operation, `cpu_mhz_o` is 100, 200, 133 or 166 for `cpu_code_o` values 0, 1, 2 and 3. It is 0 before capture.
- R7: With `dbl_rate_i` = 1 in normal operation, `cpu_mhz_o` is 200, 400, 266 or 333 for `cpu_code_o` values 0, 1, 2 and 3. The input acts without a clock edge.
- R8: After capture, later changes of `pwrgd_n_i`, of either strap pin or of both leave `cpu_code_o`, `strap_fs_o`, `test_mode_o` and `out_en_o` unchanged.
- R9: If B reads mid at the capture edge, `test_mode_o` becomes 1 and stays 1. In that mode `out_en_o` stays 0 and `cpu_mhz_o` reads 0.
- R10: In test mode, `hiz_sel_o` equals "A is high" and follows A combinationally (1 selects high impedance, 0 selects reference-divided). Changes on B have no effect. Outside test mode `hiz_sel_o` is 0.
- R11: A power-on reset clears test mode. A following power-up with B low or high then runs in normal operation.
- R12: A power-good low pulse of at least three cycles starts the sequence. The sequence completes with the R3 and R4 timing even if the strobe returns high at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_n_i | input | 1 | Power-on reset, active low, synchronous |
| pwrgd_n_i | input | 1 | Power-good strobe, active low, asynchronous |
| fsa_lvl_i | input | 2 | Strap A level code |
| fsb_lvl_i | input | 2 | Strap B level code |
| dbl_rate_i | input | 1 | Selects the doubled frequency table |
| cpu_code_o | output | 2 | Latched CPU frequency code {A, B} |
| cpu_mhz_o | output | 9 | CPU frequency in MHz, 0 if not in normal operation |
| strap_fs_o | output | 2 | Latched strap bits {B, A} for the register file |
| straps_valid_o | output | 1 | Straps have been captured |
| test_mode_o | output | 1 | Test clock mode latched |
| hiz_sel_o | output | 1 | In test mode: 1 high impedance, 0 reference-divided |
| out_en_o | output | 1 | Clock outputs enabled |

## Verification
The embedded properties check four rules on every cycle:
- The enable never coexists with test mode, and it never rises before the straps are valid.
- The enable and test mode are both sticky, and the captured values are frozen once they are valid.
- The sequencer stays idle while the synchronised strobe is high.
- The delay counter never wraps.

The exact capture and enable cycles, the level decoding, the two frequency tables and the combinational strap-A path in test mode can only be shown by the bench. It sweeps all sixteen strap-code pairs, with short and long strobe pulses and with disturbances after capture.

// File: rtl/pgs_pkg.sv
// Package: shared state type and decode helpers for the strap latch controller.
// Assumes strap level codes 00 = low, 01 = mid, 10/11 = high.
package pgs_pkg;

    typedef enum logic [2:0] {
        ST_WAIT   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_RAMP   = 3'd2,
        ST_RUN    = 3'd3,
        ST_TEST   = 3'd4
    } seq_state_t;

    // True when a level code reads as high.
    function automatic logic lvl_high(input logic [1:0] lvl);
        return (lvl == 2'b10) || (lvl == 2'b11);
    endfunction

    // True when a level code reads as mid.
    function automatic logic lvl_mid(input logic [1:0] lvl);
        return (lvl == 2'b01);
    endfunction

    // CPU frequency in MHz for a code and table choice.
    function automatic logic [8:0] code_mhz(input logic [1:0] code, input logic dbl);
        logic [8:0] mhz;
        case (code)
            2'd0:    mhz = dbl ? 9'd200 : 9'd100;
            2'd1:    mhz = dbl ? 9'd400 : 9'd200;
            2'd2:    mhz = dbl ? 9'd266 : 9'd133;
            default: mhz = dbl ? 9'd333 : 9'd166;
        endcase
        return mhz;
    endfunction

endpackage

// File: rtl/pgs_sync.sv
// Module: multi-stage synchroniser for the asynchronous power-good strobe.
// Assumes STAGES >= 2; resets to the inactive (high) level.
module pgs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) chain_q <= '1;
        else          chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pgs_dly_cnt.sv
// Module: loadable down-counter shared by the settle and ramp delays.
// Assumes the loader never asks it to decrement past zero.
module pgs_dly_cnt #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic         done_o
);

    logic [W-1:0] cnt_q;

    // Load a new delay or count down one step.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)                 cnt_q <= '0;
        else if (load_i)              cnt_q <= load_val_i;
        else if (dec_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);

    assert_no_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (cnt_q == '0 && !load_i) |=> (cnt_q == '0));

endmodule

// File: rtl/pgs_seq.sv
// Module: power-up sequencer: wait, settle, capture, ramp, run or test.
// Assumes pg_low_i is already synchronised; delay lengths are at least 2.
module pgs_seq
    import pgs_pkg::*;
#(
    parameter int SETTLE_CYC = 3600,
    parameter int RAMP_CYC   = 14318,
    parameter int CNT_W      = 14
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             pg_low_i,
    input  logic             cnt_done_i,
    input  logic             fsb_mid_i,
    output logic             cnt_load_o,
    output logic [CNT_W-1:0] cnt_val_o,
    output logic             cnt_dec_o,
    output logic             capture_o,
    output seq_state_t       state_o
);

    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] RAMP_LD   = CNT_W'(RAMP_CYC - 1);

    seq_state_t state_q, state_d;

    // Next-state and counter control decode.
    always_comb begin
        state_d    = state_q;
        cnt_load_o = 1'b0;
        cnt_val_o  = SETTLE_LD;
        cnt_dec_o  = 1'b0;
        capture_o  = 1'b0;
        case (state_q)
            ST_WAIT: begin
                if (pg_low_i) begin
                    cnt_load_o = 1'b1;
                    state_d    = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (cnt_done_i) begin
                    capture_o  = 1'b1;
                    cnt_load_o = 1'b1;
                    cnt_val_o  = RAMP_LD;
                    state_d    = fsb_mid_i ? ST_TEST : ST_RAMP;
                end else begin
                    cnt_dec_o = 1'b1;
                end
            end
            ST_RAMP: begin
                if (cnt_done_i) state_d = ST_RUN;
                else            cnt_dec_o = 1'b1;
            end
            default: state_d = state_q;
        endcase
    end

    // State register, cleared only by power-on reset.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) state_q <= ST_WAIT;
        else          state_q <= state_d;
    end

    assign state_o = state_q;

    assert_idle_until_pg_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_WAIT && !pg_low_i) |=> (state_q == ST_WAIT));

endmodule

// File: rtl/pgs_strap_latch.sv
// Module: one-shot capture of the strap pins into code, strap bits and test flag.
// Assumes capture_i pulses once per power-up; cleared only by power-on reset.
module pgs_strap_latch
    import pgs_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       capture_i,
    input  logic [1:0] fsa_lvl_i,
    input  logic [1:0] fsb_lvl_i,
    output logic [1:0] code_o,
    output logic [1:0] strap_o,
    output logic       test_o,
    output logic       valid_o
);

    logic [1:0] code_q;
    logic       test_q;
    logic       valid_q;

    // Capture the straps once and hold them until the next reset.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            code_q  <= 2'b00;
            test_q  <= 1'b0;
            valid_q <= 1'b0;
        end else if (capture_i && !valid_q) begin
            code_q  <= {lvl_high(fsa_lvl_i), lvl_high(fsb_lvl_i)};
            test_q  <= lvl_mid(fsb_lvl_i);
            valid_q <= 1'b1;
        end
    end

    assign code_o  = code_q;
    assign strap_o = {code_q[0], code_q[1]};
    assign test_o  = test_q;
    assign valid_o = valid_q;

    assert_frozen_after_capture_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (valid_q && $past(valid_q)) |-> ($stable(code_q) && $stable(test_q)));

endmodule

// File: rtl/pgood_strap_ctrl.sv
// Module: top of the power-good strap latch controller.
// Sequences power-up, captures straps once, drives output enable and test select.
// Assumes SETTLE_CYC and RAMP_CYC are at least 2 reference-clock cycles.
module pgood_strap_ctrl
    import pgs_pkg::*;
#(
    parameter int SETTLE_CYC  = 3600,
    parameter int RAMP_CYC    = 14318,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       pwrgd_n_i,
    input  logic [1:0] fsa_lvl_i,
    input  logic [1:0] fsb_lvl_i,
    input  logic       dbl_rate_i,
    output logic [1:0] cpu_code_o,
    output logic [8:0] cpu_mhz_o,
    output logic [1:0] strap_fs_o,
    output logic       straps_valid_o,
    output logic       test_mode_o,
    output logic       hiz_sel_o,
    output logic       out_en_o
);

    localparam int MAX_CYC = (SETTLE_CYC > RAMP_CYC) ? SETTLE_CYC : RAMP_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC);

    logic             pg_sync;
    logic             cnt_load, cnt_dec, cnt_done, capture;
    logic [CNT_W-1:0] cnt_val;
    seq_state_t       state;
    logic [1:0]       code;
    logic             test, valid;

    pgs_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .async_i (pwrgd_n_i),
        .sync_o  (pg_sync)
    );

    pgs_dly_cnt #(.W(CNT_W)) cnt_i (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .dec_i      (cnt_dec),
        .done_o     (cnt_done)
    );

    pgs_seq #(.SETTLE_CYC(SETTLE_CYC), .RAMP_CYC(RAMP_CYC), .CNT_W(CNT_W)) seq_i (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .pg_low_i   (!pg_sync),
        .cnt_done_i (cnt_done),
        .fsb_mid_i  (lvl_mid(fsb_lvl_i)),
        .cnt_load_o (cnt_load),
        .cnt_val_o  (cnt_val),
        .cnt_dec_o  (cnt_dec),
        .capture_o  (capture),
        .state_o    (state)
    );

    pgs_strap_latch latch_i (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .capture_i (capture),
        .fsa_lvl_i (fsa_lvl_i),
        .fsb_lvl_i (fsb_lvl_i),
        .code_o    (code),
        .strap_o   (strap_fs_o),
        .test_o    (test),
        .valid_o   (valid)
    );

    // Output decode: enable in run, live strap-A select in test, frequency in normal mode.
    always_comb begin
        out_en_o       = (state == ST_RUN);
        hiz_sel_o      = test && lvl_high(fsa_lvl_i);
        cpu_mhz_o      = (valid && !test) ? code_mhz(code, dbl_rate_i) : 9'd0;
        cpu_code_o     = code;
        test_mode_o    = test;
        straps_valid_o = valid;
    end

    assert_oe_excludes_test_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        out_en_o |-> !test_mode_o);

    assert_test_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        test_mode_o |=> test_mode_o);

    assert_oe_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        out_en_o |=> out_en_o);

    assert_oe_after_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        out_en_o |-> straps_valid_o);

endmodule

// File: tb/pgood_strap_ctrl_tb_top.sv
// Bench: sweeps every strap-code pair through a full power-up with short delays.
module pgood_strap_ctrl_tb_top;

    localparam int S = 6;
    localparam int M = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwrgd_n = 1'b1;
    logic [1:0] fsa = 2'b00;
    logic [1:0] fsb = 2'b00;
    logic       dbl = 1'b0;
    logic [1:0] cpu_code;
    logic [8:0] cpu_mhz;
    logic [1:0] strap_fs;
    logic       valid, test, hiz, oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pgood_strap_ctrl #(.SETTLE_CYC(S), .RAMP_CYC(M)) dut_i (
        .clk_i          (clk),
        .rst_n_i        (rst_n),
        .pwrgd_n_i      (pwrgd_n),
        .fsa_lvl_i      (fsa),
        .fsb_lvl_i      (fsb),
        .dbl_rate_i     (dbl),
        .cpu_code_o     (cpu_code),
        .cpu_mhz_o      (cpu_mhz),
        .strap_fs_o     (strap_fs),
        .straps_valid_o (valid),
        .test_mode_o    (test),
        .hiz_sel_o      (hiz),
        .out_en_o       (oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_mhz(input int code, input bit d);
        int base;
        base = (code == 0) ? 100 : (code == 1) ? 200 : (code == 2) ? 133 : 166;
        return d ? (2 * base + ((code == 3) ? 1 : 0)) : base;
    endfunction

    initial begin
        bit prev_test = 1'b0;
        for (int p = 0; p < 16; p++) begin
            logic [1:0] a_l, b_l;
            bit a_hi, b_hi, b_mid, short_pulse;
            int k, exp_code;
            a_l = 2'(p >> 2);
            b_l = 2'(p & 3);
            a_hi = (a_l >= 2);
            b_hi = (b_l >= 2);
            b_mid = (b_l == 2'b01);
            short_pulse = (p % 2 == 1);
            exp_code = {30'd0, a_hi, b_hi};
            // power-on reset
            @(negedge clk);
            rst_n = 1'b0; pwrgd_n = 1'b1; fsa = a_l; fsb = b_l; dbl = 1'b0;
            repeat (3) @(negedge clk);
            check(!valid && !test && !oe && !hiz && cpu_code == 0 && strap_fs == 0 && cpu_mhz == 0,
                  "R1 reset state", {valid, test, oe, hiz}, 0);
            if (prev_test) check(!test, "R11 reset clears test", test, 0);
            rst_n = 1'b1;
            // no power-good yet
            repeat (12) @(negedge clk);
            check(!valid && !oe, "R2 idle without power-good", valid, 0);
            // assert power-good
            pwrgd_n = 1'b0;
            k = 0;
            while (!valid && k < 100) begin
                @(negedge clk);
                k++;
                if (short_pulse && k == 3) pwrgd_n = 1'b1;
            end
            check(k == S + 3, short_pulse ? "R12 short pulse capture time" : "R3 capture time", k, S + 3);
            check(int'(cpu_code) == exp_code, "R5 latched code", cpu_code, exp_code);
            check(strap_fs == {b_hi, a_hi}, "R5 strap bits", strap_fs, {b_hi, a_hi});
            check(test == b_mid, "R9 test flag", test, b_mid);
            if (b_mid) begin
                repeat (M + 6) @(negedge clk);
                check(!oe && cpu_mhz == 0 && test, "R9 outputs off in test", oe, 0);
                for (int v = 0; v < 4; v++) begin
                    fsa = 2'(v);
                    #0.5;
                    check(hiz == (v >= 2), "R10 live A select", hiz, v >= 2);
                end
                fsb = 2'b00; @(negedge clk); fsb = 2'b10; @(negedge clk);
                fsa = 2'b10; #0.5;
                check(test && hiz && !oe, "R10 B ignored in test", test, 1);
                fsa = 2'b00; #0.5;
                check(!hiz, "R10 A low gives reference-divided", hiz, 0);
                prev_test = 1'b1;
            end else begin
                check(!hiz, "R10 no select outside test", hiz, 0);
                while (!oe && k < 200) begin
                    @(negedge clk);
                    k++;
                end
                check(k == S + M + 3, "R4 enable time", k, S + M + 3);
                check(int'(cpu_mhz) == exp_mhz(exp_code, 1'b0), "R6 normal table", cpu_mhz, exp_mhz(exp_code, 1'b0));
                dbl = 1'b1; #0.5;
                check(int'(cpu_mhz) == exp_mhz(exp_code, 1'b1), "R7 doubled table", cpu_mhz, exp_mhz(exp_code, 1'b1));
                dbl = 1'b0;
                // disturb everything after capture
                fsa = ~a_l; fsb = 2'b01; pwrgd_n = 1'b1;
                repeat (5) @(negedge clk);
                pwrgd_n = 1'b0; fsb = ~b_l;
                repeat (20) @(negedge clk);
                check(int'(cpu_code) == exp_code && strap_fs == {b_hi, a_hi} && oe && !test,
                      "R8 later changes ignored", cpu_code, exp_code);
                prev_test = 1'b0;
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule